// File: doc/BRIEF.md
# Control Store Memory Self-Test Sequencer

This block is a built-in self-test engine for a word-organised control store, by default 1024 words of 24 bits. After a one-cycle start pulse it drives the memory's write and read strobes, address and write data through a fixed series of pattern tests. Each read word is compared against the word the test expects at that address. The first mismatch freezes a record of the failing address, the expected word and the word actually read, and the engine halts.

Every test works from two patterns: a test word and a background word. It runs once with these patterns and once more with them complemented. The expected data is a function of the address. Depending on the test, it follows a walking bit, the address parity, the XOR of two address bits, or a single roving test location. The memory sits outside the block, has a read latency of one cycle, and is never written and read in the same cycle.

Top module: `cbist_top`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), mem_we, mem_re, done, pass_ok and err are 0, and err_addr, err_exp and err_act are all zero.
- R2: Walking test, run first. For pass p = 0 .. DATA_W-1, every address is written in ascending order with a word in which only bit DATA_W-1-p is set. Every address is then read back in ascending order. The same DATA_W passes then repeat with every word complemented, giving a single 0 among ones.
- R3: Lonely-bit test. First every address is written with the background. Then, for each location L from 0 to the last address: L is written with the test word, then L-1 is written with the background (only when L > 0), then every address is read in ascending order. The expected word is the test word at L and the background elsewhere. The first round uses test = all ones and background = all zeros; the second round swaps them.
- R4: Parity test. Addresses with an even number of 1 bits get the test word and all other addresses get the background. There is one ascending write pass, then one ascending read pass. The first round uses test = all ones and background = zeros; the second round swaps them.
- R5: Checkerboard test. An address gets the background when its bits 0 and 5 are equal and the test word when they differ. There is one write pass and one read pass, first with test = ones and background = zeros, then complemented.
- R6: Alternating test, run last. The word with every odd-numbered bit set (0xAAAAAA) is written to every address and read back from every address. The same is then done with its complement 0x555555.
- R7: The tests run in the order walking, lonely-bit, parity, checkerboard, alternating. From the cycle after start is accepted, exactly one memory operation (mem_we or mem_re) is issued in every cycle until the last read, with no idle cycles between operations.
- R8: The data returned one cycle after a read is compared with the expected word for that read's address.
- R9: On the first mismatch, err_addr, err_exp and err_act hold the failing address, the expected word and the returned word. In the following cycle err and done are 1, and pass_ok is 0. After the operation already issued in the compare cycle, no further memory operation is issued.
- R10: With no mismatch, done and pass_ok become 1 two cycles after the cycle of the last read, err stays 0, and no memory operation is issued from the cycle after the last read onward.
- R11: A start pulse while the sequence is running has no effect on the operation stream. A start pulse after done begins a new run, and clears done, pass_ok, err and the captured fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a self-test run when the engine is idle |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe; data returns next cycle |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid the cycle after mem_re |
| done | output | 1 | Run finished or halted on a mismatch |
| pass_ok | output | 1 | Run finished with no mismatch |
| err | output | 1 | A mismatch was found |
| err_addr | output | ADDR_W | Address of the first mismatch |
| err_exp | output | DATA_W | Expected word at the first mismatch |
| err_act | output | DATA_W | Word read at the first mismatch |

## Verification
The bench builds, with loops of its own, the full list of writes and reads every test should issue, and compares the engine's memory port against that list on every cycle. A clean memory run exercises every pattern family. It shows that the walking bit moves from MSB downwards, that parity and the bit-0/bit-5 checkerboard select the correct word, and that the lonely location and its restore land on the right addresses. A second run injects a stuck-at-0 bit at one address. The bench predicts the first read that exposes the fault, and this separates correct capture and halting from an off-by-one in the compare pipeline. A start pulse in the middle of a run, and a clean rerun after the failure, show that restarts are ignored while running and that a new run clears the error state.

// File: rtl/cbist_pkg.sv
// Shared types for the control store self-test engine.
package cbist_pkg;
    // Test families in run order.
    typedef enum logic [2:0] {
        T_WALK   = 3'd0,
        T_LONELY = 3'd1,
        T_PARITY = 3'd2,
        T_CHECK  = 3'd3,
        T_ALT    = 3'd4
    } test_e;

    // Step kinds inside one test round.
    typedef enum logic [2:0] {
        PH_FILL    = 3'd0,
        PH_SET     = 3'd1,
        PH_RESTORE = 3'd2,
        PH_WRITE   = 3'd3,
        PH_READ    = 3'd4
    } phase_e;

    // Engine run state.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } run_e;
endpackage

// File: rtl/cbist_patgen.sv
// Pattern generator: computes the word for a given test, polarity, pass
// and address. Purely combinational. Assumes ADDR_W > CB_HI.
module cbist_patgen #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 24,
    parameter int PASS_W = 11,
    parameter int CB_HI  = 5
) (
    input  cbist_pkg::test_e    test,
    input  logic                pol,
    input  logic [PASS_W-1:0]   pass,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                bg_only,
    output logic [DATA_W-1:0]   word
);
    import cbist_pkg::*;

    logic [DATA_W-1:0] walk_w;
    logic [DATA_W-1:0] alt_w;
    logic [DATA_W-1:0] raw_w;

    // Single bit that moves down from the MSB as pass advances.
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            walk_w[i] = (pass == PASS_W'(DATA_W - 1 - i));
        end
    end

    // Alternating word with odd-numbered bits set.
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            alt_w[i] = ((i % 2) == 1);
        end
    end

    // Select the true-polarity word for the current test.
    always_comb begin
        case (test)
            T_WALK:   raw_w = walk_w;
            T_LONELY: raw_w = {DATA_W{addr == pass[ADDR_W-1:0]}};
            T_PARITY: raw_w = {DATA_W{~^addr}};
            T_CHECK:  raw_w = {DATA_W{addr[0] ^ addr[CB_HI]}};
            T_ALT:    raw_w = alt_w;
            default:  raw_w = '0;
        endcase
        if (bg_only) raw_w = '0;
    end

    // Apply the round's polarity.
    assign word = raw_w ^ {DATA_W{pol}};
endmodule

// File: rtl/cbist_seq.sv
// Sequencer: steps tests, rounds, passes and addresses, issuing one memory
// operation per cycle while running. Halts when the comparator reports a
// mismatch. Assumes the memory accepts a new operation every cycle.
module cbist_seq #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 24,
    parameter int CB_HI  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              fail,
    output logic              mem_we,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              accept,
    output logic              done
);
    import cbist_pkg::*;

    localparam int DW_BITS = $clog2(DATA_W);
    localparam int PASS_W  = ((ADDR_W > DW_BITS) ? ADDR_W : DW_BITS) + 1;
    localparam int DEPTH   = 1 << ADDR_W;

    run_e              st_q,   st_n;
    test_e             test_q, test_n;
    phase_e            ph_q,   ph_n;
    logic              pol_q,  pol_n;
    logic [PASS_W-1:0] pass_q, pass_n;
    logic [ADDR_W-1:0] addr_q, addr_n;
    logic              done_q, done_n;
    logic              last_addr, last_pass;
    logic [ADDR_W-1:0] op_addr;

    // First step of a round for a given test.
    function automatic phase_e first_phase(input test_e t);
        return (t == T_LONELY) ? PH_FILL : PH_WRITE;
    endfunction

    // Address driven for the current step.
    always_comb begin
        case (ph_q)
            PH_SET:     op_addr = pass_q[ADDR_W-1:0];
            PH_RESTORE: op_addr = pass_q[ADDR_W-1:0] - ADDR_W'(1);
            default:    op_addr = addr_q;
        endcase
    end

    cbist_patgen #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PASS_W (PASS_W),
        .CB_HI  (CB_HI)
    ) u_pat (
        .test    (test_q),
        .pol     (pol_q),
        .pass    (pass_q),
        .addr    (op_addr),
        .bg_only (ph_q == PH_FILL),
        .word    (mem_wdata)
    );

    assign mem_we   = (st_q == ST_RUN) && (ph_q != PH_READ);
    assign mem_re   = (st_q == ST_RUN) && (ph_q == PH_READ);
    assign mem_addr = op_addr;
    assign accept   = start && (st_q == ST_IDLE);
    assign done     = done_q;

    // End-of-sweep and end-of-round conditions.
    always_comb begin
        last_addr = (addr_q == {ADDR_W{1'b1}});
        case (test_q)
            T_WALK:   last_pass = (pass_q == PASS_W'(DATA_W - 1));
            T_LONELY: last_pass = (pass_q == PASS_W'(DEPTH - 1));
            default:  last_pass = 1'b1;
        endcase
    end

    // Next-state logic for the step counters and run state.
    always_comb begin
        st_n   = st_q;
        test_n = test_q;
        ph_n   = ph_q;
        pol_n  = pol_q;
        pass_n = pass_q;
        addr_n = addr_q;
        done_n = done_q;
        case (st_q)
            ST_IDLE: begin
                if (start) begin
                    st_n   = ST_RUN;
                    test_n = T_WALK;
                    ph_n   = first_phase(T_WALK);
                    pol_n  = 1'b0;
                    pass_n = '0;
                    addr_n = '0;
                    done_n = 1'b0;
                end
            end
            ST_RUN: begin
                if (fail) begin
                    st_n   = ST_IDLE;
                    done_n = 1'b1;
                end else begin
                    case (ph_q)
                        PH_FILL: begin
                            addr_n = addr_q + ADDR_W'(1);
                            if (last_addr) ph_n = PH_SET;
                        end
                        PH_SET: begin
                            addr_n = '0;
                            ph_n   = (pass_q != '0) ? PH_RESTORE : PH_READ;
                        end
                        PH_RESTORE: begin
                            addr_n = '0;
                            ph_n   = PH_READ;
                        end
                        PH_WRITE: begin
                            addr_n = addr_q + ADDR_W'(1);
                            if (last_addr) ph_n = PH_READ;
                        end
                        default: begin
                            addr_n = addr_q + ADDR_W'(1);
                            if (last_addr) begin
                                if (!last_pass) begin
                                    pass_n = pass_q + PASS_W'(1);
                                    ph_n   = (test_q == T_LONELY) ? PH_SET : PH_WRITE;
                                end else if (!pol_q) begin
                                    pol_n  = 1'b1;
                                    pass_n = '0;
                                    ph_n   = first_phase(test_q);
                                end else if (test_q == T_ALT) begin
                                    st_n   = ST_DRAIN;
                                end else begin
                                    test_n = test_e'(test_q + 3'd1);
                                    pol_n  = 1'b0;
                                    pass_n = '0;
                                    ph_n   = first_phase(test_e'(test_q + 3'd1));
                                end
                            end
                        end
                    endcase
                end
            end
            default: begin
                st_n   = ST_IDLE;
                done_n = 1'b1;
            end
        endcase
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            test_q <= T_WALK;
            ph_q   <= PH_WRITE;
            pol_q  <= 1'b0;
            pass_q <= '0;
            addr_q <= '0;
            done_q <= 1'b0;
        end else begin
            st_q   <= st_n;
            test_q <= test_n;
            ph_q   <= ph_n;
            pol_q  <= pol_n;
            pass_q <= pass_n;
            addr_q <= addr_n;
            done_q <= done_n;
        end
    end

    // R9: nothing is issued after the compare cycle that failed.
    a_r9_halt_after_fail: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> (!mem_we && !mem_re && done));

    // R10: a finished engine leaves the memory idle.
    a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mem_we && !mem_re));

    // R11: start while running does not restart or finish the run.
    a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && start && !fail) |=> (st_q != ST_IDLE && !done));

    // R2: the first walking round writes words with exactly one bit set.
    a_r2_walk_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && test_q == T_WALK && !pol_q) |-> ($countones(mem_wdata) == 1));

    // R7: read sweeps step the address by one each cycle.
    a_r7_read_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re && !last_addr && !fail) |=> (mem_re && mem_addr == $past(mem_addr) + ADDR_W'(1)));
endmodule

// File: rtl/cbist_cmp.sv
// Comparator: delays the expected word and address by one cycle to line up
// with read data, flags the first mismatch and holds its record.
// Assumes read data is valid exactly one cycle after the read strobe.
module cbist_cmp #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_exp,
    input  logic [DATA_W-1:0] rdata,
    output logic              fail,
    output logic              err,
    output logic [ADDR_W-1:0] err_addr,
    output logic [DATA_W-1:0] err_exp,
    output logic [DATA_W-1:0] err_act
);
    logic              rv_q;
    logic [ADDR_W-1:0] ra_q;
    logic [DATA_W-1:0] re_q;

    // Mismatch on the returning read, first one only.
    assign fail = rv_q && (rdata != re_q) && !err;

    // Alignment stage for the read in flight.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rv_q <= 1'b0;
            ra_q <= '0;
            re_q <= '0;
        end else begin
            rv_q <= rd_en;
            ra_q <= rd_addr;
            re_q <= rd_exp;
        end
    end

    // Error record, captured once per run.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            err      <= 1'b0;
            err_addr <= '0;
            err_exp  <= '0;
            err_act  <= '0;
        end else if (fail) begin
            err      <= 1'b1;
            err_addr <= ra_q;
            err_exp  <= re_q;
            err_act  <= rdata;
        end
    end

    // R8: an error is raised only two edges after a read was issued.
    a_r8_err_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(rd_en, 2));

    // R9: the record holds until a new run clears it.
    a_r9_record_held: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !clr) |=> (err && $stable(err_addr) && $stable(err_exp) && $stable(err_act)));
endmodule

// File: rtl/cbist_top.sv
// Control store self-test engine top: sequencer plus read comparator.
// Assumes an external synchronous RAM with one-cycle read latency.
module cbist_top #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 24,
    parameter int CB_HI  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              mem_we,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic              pass_ok,
    output logic              err,
    output logic [ADDR_W-1:0] err_addr,
    output logic [DATA_W-1:0] err_exp,
    output logic [DATA_W-1:0] err_act
);
    logic fail;
    logic accept;

    cbist_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CB_HI  (CB_HI)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .fail      (fail),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .accept    (accept),
        .done      (done)
    );

    cbist_cmp #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (accept),
        .rd_en    (mem_re),
        .rd_addr  (mem_addr),
        .rd_exp   (mem_wdata),
        .rdata    (mem_rdata),
        .fail     (fail),
        .err      (err),
        .err_addr (err_addr),
        .err_exp  (err_exp),
        .err_act  (err_act)
    );

    assign pass_ok = done && !err;
endmodule

// File: tb/tb_cbist_top.sv
module tb_cbist_top;
    localparam int AW    = 6;
    localparam int DW    = 24;
    localparam int DEPTH = 1 << AW;
    localparam int FA    = 5;
    localparam int FB    = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          mem_we, mem_re, done, pass_ok, err;
    logic [AW-1:0] mem_addr, err_addr;
    logic [DW-1:0] mem_wdata, err_exp, err_act;
    logic [DW-1:0] mem_rdata = '0;
    logic [DW-1:0] mem [0:DEPTH-1];
    bit            fault_on = 1'b0;
    bit            finished = 1'b0;
    int            total = 0;
    int            bad = 0;

    typedef struct {
        bit          we;
        bit          re;
        int          addr;
        logic [DW-1:0] d;
        int          tst;
    } op_t;
    op_t q[$];

    always #5 clk = ~clk;

    cbist_top #(.ADDR_W(AW), .DATA_W(DW), .CB_HI(5)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done), .pass_ok(pass_ok), .err(err),
        .err_addr(err_addr), .err_exp(err_exp), .err_act(err_act)
    );

    // Memory model with an optional stuck-at-0 bit at one address.
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= (fault_on && mem_addr == AW'(FA)) ?
                                     (mem_wdata & ~(DW'(1) << FB)) : mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr];
    end

    function automatic string tag_of(input int t);
        case (t)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            default: return "R6";
        endcase
    endfunction

    function automatic logic [DW-1:0] ref_word(input int t, input int pol, input int p, input int a);
        logic [DW-1:0] w;
        int ones;
        w = '0;
        case (t)
            0: w[DW-1-p] = 1'b1;
            1: w = (a == p) ? '1 : '0;
            2: begin
                ones = 0;
                for (int b = 0; b < AW; b++) ones += (a >> b) & 1;
                w = (ones % 2 == 0) ? '1 : '0;
            end
            3: w = ((a & 1) != ((a >> 5) & 1)) ? '1 : '0;
            default: w = 24'hAAAAAA;
        endcase
        return pol ? ~w : w;
    endfunction

    function automatic op_t mk(input bit we, input int a, input logic [DW-1:0] d, input int t);
        op_t o;
        o.we = we; o.re = !we; o.addr = a; o.d = d; o.tst = t;
        return o;
    endfunction

    task automatic build_ref();
        q.delete();
        for (int t = 0; t < 5; t++) begin
            for (int pol = 0; pol < 2; pol++) begin
                if (t == 1) begin
                    for (int a = 0; a < DEPTH; a++) q.push_back(mk(1, a, pol ? '1 : '0, t));
                    for (int loc = 0; loc < DEPTH; loc++) begin
                        q.push_back(mk(1, loc, ref_word(t, pol, loc, loc), t));
                        if (loc > 0) q.push_back(mk(1, loc - 1, ref_word(t, pol, loc, loc - 1), t));
                        for (int a = 0; a < DEPTH; a++) q.push_back(mk(0, a, ref_word(t, pol, loc, a), t));
                    end
                end else begin
                    for (int p = 0; p < ((t == 0) ? DW : 1); p++) begin
                        for (int a = 0; a < DEPTH; a++) q.push_back(mk(1, a, ref_word(t, pol, p, a), t));
                        for (int a = 0; a < DEPTH; a++) q.push_back(mk(0, a, ref_word(t, pol, p, a), t));
                    end
                end
            end
        end
    endtask

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // One run: reference stream compared with the memory port every cycle.
    task automatic run_once(input bit faulty, input bit poke);
        logic [DW-1:0] mm [0:DEPTH-1];
        int k, n_issue, end_i;
        logic [DW-1:0] f_exp, f_act;
        int f_addr;
        build_ref();
        k = -1; f_exp = '0; f_act = '0; f_addr = 0;
        for (int i = 0; i < q.size(); i++) begin
            if (q[i].we) mm[q[i].addr] = (faulty && q[i].addr == FA) ?
                                          (q[i].d & ~(DW'(1) << FB)) : q[i].d;
            else if (mm[q[i].addr] != q[i].d) begin
                k = i; f_exp = q[i].d; f_act = mm[q[i].addr]; f_addr = q[i].addr;
                break;
            end
        end
        if (k >= 0) begin
            n_issue = (k + 2 < q.size()) ? k + 2 : q.size();
            end_i = k + 2;
        end else begin
            n_issue = q.size();
            end_i = q.size() + 1;
        end
        fault_on = faulty;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i <= end_i + 2; i++) begin
            if (poke) start = (i == 100);
            if (i < n_issue) begin
                chk(mem_we == q[i].we && mem_re == q[i].re && int'(mem_addr) == q[i].addr &&
                    (!q[i].we || mem_wdata == q[i].d),
                    tag_of(q[i].tst), $sformatf("R7 op %0d addr/data", i),
                    {mem_we, mem_re, 22'd0, mem_addr, mem_wdata},
                    {q[i].we, q[i].re, 22'd0, AW'(q[i].addr), q[i].d});
            end else begin
                chk(!mem_we && !mem_re, (k >= 0) ? "R9" : "R10", "memory idle after end",
                    {mem_we, mem_re}, 0);
            end
            chk(done == (i >= end_i), (k >= 0) ? "R9" : "R10", $sformatf("done at cycle %0d", i),
                done, (i >= end_i));
            @(negedge clk);
        end
        start = 1'b0;
        chk(err == (k >= 0), "R9", "err flag", err, (k >= 0));
        chk(pass_ok == (k < 0), "R10", "pass_ok", pass_ok, (k < 0));
        if (k >= 0) begin
            chk(int'(err_addr) == f_addr, "R9", "captured address", err_addr, f_addr);
            chk(err_exp == f_exp, "R9", "captured expected", err_exp, f_exp);
            chk(err_act == f_act, "R8", "captured actual", err_act, f_act);
        end else begin
            chk(err_addr == '0 && err_exp == '0 && err_act == '0, "R11",
                "record cleared by new run", {err_addr, err_exp}, 0);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!mem_we && !mem_re && !done && !pass_ok && !err, "R1", "control outputs after reset",
            {mem_we, mem_re, done, pass_ok, err}, 0);
        chk(err_addr == '0 && err_exp == '0 && err_act == '0, "R1", "record after reset",
            {err_addr, err_exp, err_act}, 0);
        run_once(1'b0, 1'b1);   // clean run with a start poke mid-run (R11)
        run_once(1'b1, 1'b0);   // stuck-at fault run (R9)
        run_once(1'b0, 1'b0);   // clean rerun clears the error (R11)
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule